// File: doc/BRIEF.md
# ECC Read-Modify-Write Partial-Write Engine

This block stands between a local request port and a word-wide memory port and keeps every stored word under a single-error-correcting, double-error-detecting Hamming code. Each 32-bit data word is kept in memory as a 39-bit codeword. A write that enables all four bytes is encoded and sent to memory as one write. A write that leaves any byte enable clear becomes a read-modify-write. The engine fetches the stored codeword and decodes it. It corrects the word if it can, replaces the enabled bytes with the new data, and writes back a complete codeword with freshly computed check bits.

Ordinary reads also pass through the decoder. They return corrected data, and a read-error flag marks an uncorrectable word. Single-bit and double-bit events from either path go to two saturating counters. A double-bit event raises an interrupt. The address and the origin of the first uncorrectable error are held in a status record until software clears it.

Top module: `ecc_rmw_engine`

## Requirements
- R1: A write with all four byte enables set produces exactly one memory write of the encoded word and no memory read.
- R2: A write with any byte enable clear produces one memory read of the addressed word and then one memory write. The written word holds the new bytes where `lcl_be[b]` is set (byte b is bits 8b+7..8b) and the stored, corrected bytes elsewhere.
- R3: `lcl_ready` is low from the cycle after a partial write is accepted until its write-back is issued. A read of the same address that follows at once returns the merged word.
- R4: A read returns the stored data with any single flipped data bit corrected, and `lcl_rerr` low.
- R5: A single flipped check bit returns unchanged data with `lcl_rerr` low and is counted as a single-bit error. This covers any power-of-two Hamming position and also the overall parity bit 38.
- R6: `sbe_cnt` rises by one for each single-bit error found by an ordinary read or by the read phase of a read-modify-write. The write-back of a read-modify-write stores the corrected word, so a later read of that word finds no error.
- R7: On a double-bit error, `dbe_cnt` rises by one and `irq` goes high. On an ordinary read, `lcl_rerr` is also high and `lcl_rdata` is the uncorrected data field.
- R8: A double-bit error in the read phase of a read-modify-write still produces the write. The new bytes are merged over the uncorrected data field, and the result is stored with fresh check bits, so a later read of it is clean.
- R9: `stat_addr` and `stat_type` hold the first double-bit error. Type 01 marks an ordinary read and type 10 marks a read-modify-write. The record stays unchanged by later errors until a `stat_clr` pulse, which also lowers `irq` and `stat_valid`.
- R10: Both counters stop at 2^CNT_W-1 without wrapping, and a `cnt_clr` pulse sets both to zero.
- R11: The codeword layout is fixed. Bit i-1 holds Hamming position i for i = 1..38, and check bits sit at the power-of-two positions. Data bits fill the other positions in ascending order: d0 at position 3, d1 at 5, d2 at 6, d3 at 7, d4 at 9, d5 at 10. Bit 38 makes the even parity of all 39 bits. The memory port has no byte mask, and every memory write carries a whole codeword.
- R12: After reset, `lcl_ready` is high. `irq`, `stat_valid`, `lcl_rvalid` and `mem_req` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request valid |
| lcl_ready | output | 1 | Engine can accept a request |
| lcl_write | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | ADDR_W | Word address |
| lcl_wdata | input | 32 | Write data |
| lcl_be | input | 4 | Byte enables for the write |
| lcl_rvalid | output | 1 | Read data valid (one cycle) |
| lcl_rdata | output | 32 | Corrected read data |
| lcl_rerr | output | 1 | Read data uncorrectable |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 39 | Codeword to store |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 39 | Codeword read from memory |
| irq | output | 1 | Double-bit error interrupt |
| stat_clr | input | 1 | Write-one-to-clear strobe for status and interrupt |
| cnt_clr | input | 1 | Clear both counters |
| sbe_cnt | output | CNT_W | Single-bit error count |
| dbe_cnt | output | CNT_W | Double-bit error count |
| stat_valid | output | 1 | Status record holds an error |
| stat_type | output | 2 | Origin of the recorded error |
| stat_addr | output | ADDR_W | Address of the recorded error |

## Verification
The hardest case to reach is a double-bit error in the read phase of a partial write, followed by the write-back whose content depends on the uncorrected data field. The bench owns the memory model and can flip chosen codeword bits at rest after a write has landed. It flips positions 3 and 5, which are data bits 0 and 1. It then issues a partial write whose enabled byte misses those bits, and reads the word back to confirm the corrupt low byte and the new byte together with a clean code. It also reads one word with a single flipped bit repeatedly, which drives the counter into saturation with a narrow counter width.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int BE_W   = DATA_W / BYTE_W;
    localparam int HAM_N  = 38;
    localparam int SYN_W  = 6;
    localparam int CW_W   = HAM_N + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_RMW  = 2'd2
    } eng_state_e;

    localparam logic [1:0] SRC_NONE = 2'b00;
    localparam logic [1:0] SRC_READ = 2'b01;
    localparam logic [1:0] SRC_RMW  = 2'b10;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Spread data bits over the non-power-of-two Hamming positions.
    function automatic logic [CW_W-1:0] place_data(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (!is_pow2(p)) begin
                r[p-1] = d[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pull_data(input logic [CW_W-1:0] c);
        logic [DATA_W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (!is_pow2(p)) begin
                r[k] = c[p-1];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [SYN_W-1:0] syndrome(input logic [CW_W-1:0] c);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (c[p-1]) s = s ^ SYN_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_rmw_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:0]  base;
    logic [SYN_W-1:0] syn;

    always_comb begin
        base = place_data(data_i);
        syn  = syndrome(base);
        // Check positions are still zero, so the syndrome gives their values.
        for (int j = 0; j < SYN_W; j++) begin
            base[(1 << j) - 1] = syn[j];
        end
        base[CW_W-1] = ^base[HAM_N-1:0];
        cw_o = base;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_rmw_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sbe_o,
    output logic              dbe_o
);

    logic [SYN_W-1:0] syn;
    logic             par;
    logic [CW_W-1:0]  fixed;
    int               pos;

    always_comb begin
        syn   = syndrome(cw_i);
        par   = ^cw_i;
        fixed = cw_i;
        sbe_o = 1'b0;
        dbe_o = 1'b0;
        pos   = int'(syn);
        if (par) begin
            if (pos == 0) begin
                sbe_o = 1'b1;               // overall parity bit alone
            end else if (pos <= HAM_N) begin
                sbe_o = 1'b1;
                fixed[pos-1] = ~fixed[pos-1];
            end else begin
                dbe_o = 1'b1;               // syndrome points outside the word
            end
        end else if (pos != 0) begin
            dbe_o = 1'b1;
        end
        data_o = pull_data(fixed);
    end

endmodule

// File: rtl/ecc_err_track.sv
module ecc_err_track
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_sbe,
    input  logic              ev_dbe,
    input  logic              ev_rmw,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              stat_clr,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  sbe_cnt,
    output logic [CNT_W-1:0]  dbe_cnt,
    output logic              irq,
    output logic              stat_valid,
    output logic [1:0]        stat_type,
    output logic [ADDR_W-1:0] stat_addr
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  sbe;
        logic [CNT_W-1:0]  dbe;
        logic              irq;
        logic              valid;
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (stat_clr) begin
            trk_d.irq   = 1'b0;
            trk_d.valid = 1'b0;
            trk_d.kind  = SRC_NONE;
            trk_d.addr  = '0;
        end
        if (cnt_clr) begin
            trk_d.sbe = '0;
            trk_d.dbe = '0;
        end
        if (ev_valid && ev_sbe && !cnt_clr && trk_q.sbe != CNT_MAX) begin
            trk_d.sbe = trk_q.sbe + CNT_W'(1);
        end
        if (ev_valid && ev_dbe) begin
            if (!cnt_clr && trk_q.dbe != CNT_MAX) begin
                trk_d.dbe = trk_q.dbe + CNT_W'(1);
            end
            trk_d.irq = 1'b1;
            if (!trk_d.valid) begin
                trk_d.valid = 1'b1;
                trk_d.kind  = ev_rmw ? SRC_RMW : SRC_READ;
                trk_d.addr  = ev_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign sbe_cnt    = trk_q.sbe;
    assign dbe_cnt    = trk_q.dbe;
    assign irq        = trk_q.irq;
    assign stat_valid = trk_q.valid;
    assign stat_type  = trk_q.kind;
    assign stat_addr  = trk_q.addr;

endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_valid,
    output logic              lcl_ready,
    input  logic              lcl_write,
    input  logic [ADDR_W-1:0] lcl_addr,
    input  logic [DATA_W-1:0] lcl_wdata,
    input  logic [BE_W-1:0]   lcl_be,
    output logic              lcl_rvalid,
    output logic [DATA_W-1:0] lcl_rdata,
    output logic              lcl_rerr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CW_W-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [CW_W-1:0]   mem_rdata,
    output logic              irq,
    input  logic              stat_clr,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  sbe_cnt,
    output logic [CNT_W-1:0]  dbe_cnt,
    output logic              stat_valid,
    output logic [1:0]        stat_type,
    output logic [ADDR_W-1:0] stat_addr
);

    typedef struct packed {
        eng_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [CW_W-1:0]   mwdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              rerr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [DATA_W-1:0] dec_data;
    logic              dec_sbe;
    logic              dec_dbe;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] enc_in;
    logic [CW_W-1:0]   enc_cw;
    logic              ev_valid;
    logic              ev_rmw;

    secded_dec u_dec (
        .cw_i   (mem_rdata),
        .data_o (dec_data),
        .sbe_o  (dec_sbe),
        .dbe_o  (dec_dbe)
    );

    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[b*BYTE_W +: BYTE_W] = eng_q.be[b]
            ? eng_q.wdata[b*BYTE_W +: BYTE_W]
            : dec_data[b*BYTE_W +: BYTE_W];
    end

    assign enc_in = (eng_q.state == ST_RMW) ? merged : lcl_wdata;

    secded_enc u_enc (
        .data_i (enc_in),
        .cw_o   (enc_cw)
    );

    always_comb begin
        eng_d        = eng_q;
        eng_d.mreq   = 1'b0;
        eng_d.rvalid = 1'b0;
        ev_valid     = 1'b0;
        ev_rmw       = 1'b0;
        unique case (eng_q.state)
            ST_IDLE: begin
                if (lcl_valid) begin
                    eng_d.addr  = lcl_addr;
                    eng_d.wdata = lcl_wdata;
                    eng_d.be    = lcl_be;
                    eng_d.mreq  = 1'b1;
                    eng_d.maddr = lcl_addr;
                    if (lcl_write && (&lcl_be)) begin
                        eng_d.mwe    = 1'b1;
                        eng_d.mwdata = enc_cw;
                    end else begin
                        eng_d.mwe   = 1'b0;
                        eng_d.state = lcl_write ? ST_RMW : ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (mem_rvalid) begin
                    ev_valid     = 1'b1;
                    eng_d.rvalid = 1'b1;
                    eng_d.rdata  = dec_data;
                    eng_d.rerr   = dec_dbe;
                    eng_d.state  = ST_IDLE;
                end
            end
            ST_RMW: begin
                if (mem_rvalid) begin
                    ev_valid     = 1'b1;
                    ev_rmw       = 1'b1;
                    eng_d.mreq   = 1'b1;
                    eng_d.mwe    = 1'b1;
                    eng_d.maddr  = eng_q.addr;
                    eng_d.mwdata = enc_cw;
                    eng_d.state  = ST_IDLE;
                end
            end
            default: eng_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    ecc_err_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_sbe     (dec_sbe),
        .ev_dbe     (dec_dbe),
        .ev_rmw     (ev_rmw),
        .ev_addr    (eng_q.addr),
        .stat_clr   (stat_clr),
        .cnt_clr    (cnt_clr),
        .sbe_cnt    (sbe_cnt),
        .dbe_cnt    (dbe_cnt),
        .irq        (irq),
        .stat_valid (stat_valid),
        .stat_type  (stat_type),
        .stat_addr  (stat_addr)
    );

    assign lcl_ready  = (eng_q.state == ST_IDLE);
    assign lcl_rvalid = eng_q.rvalid;
    assign lcl_rdata  = eng_q.rdata;
    assign lcl_rerr   = eng_q.rerr;
    assign mem_req    = eng_q.mreq;
    assign mem_we     = eng_q.mwe;
    assign mem_addr   = eng_q.maddr;
    assign mem_wdata  = eng_q.mwdata;

endmodule

// File: rtl/ecc_rmw_engine_chk.sv
module ecc_rmw_engine_chk
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lcl_valid,
    input logic              lcl_ready,
    input logic              lcl_write,
    input logic [BE_W-1:0]   lcl_be,
    input logic              lcl_rvalid,
    input logic              lcl_rerr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rvalid,
    input logic              irq,
    input logic              stat_clr,
    input logic              cnt_clr,
    input logic [CNT_W-1:0]  sbe_cnt,
    input logic              stat_valid,
    input logic [ADDR_W-1:0] stat_addr
);

    logic take_full;
    logic take_part;
    assign take_full = lcl_valid && lcl_ready && lcl_write && (&lcl_be);
    assign take_part = lcl_valid && lcl_ready && lcl_write && !(&lcl_be);

    AST_FULL_WR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        take_full |=> (mem_req && mem_we)); // R1

    AST_PART_WR_READS: assert property (@(posedge clk) disable iff (!rst_n)
        take_part |=> (mem_req && !mem_we)); // R2

    AST_RMW_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        take_part |=> !lcl_ready); // R3

    AST_RVALID_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_rvalid |-> $past(mem_rvalid)); // R4

    AST_RERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_rvalid && lcl_rerr) |-> irq); // R7

    AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && $past(stat_valid) && !$past(stat_clr)) |-> $stable(stat_addr)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clr) && ($past(sbe_cnt) == {CNT_W{1'b1}})) |-> (sbe_cnt == {CNT_W{1'b1}})); // R10

endmodule

bind ecc_rmw_engine ecc_rmw_engine_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcl_valid  (lcl_valid),
    .lcl_ready  (lcl_ready),
    .lcl_write  (lcl_write),
    .lcl_be     (lcl_be),
    .lcl_rvalid (lcl_rvalid),
    .lcl_rerr   (lcl_rerr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .irq        (irq),
    .stat_clr   (stat_clr),
    .cnt_clr    (cnt_clr),
    .sbe_cnt    (sbe_cnt),
    .stat_valid (stat_valid),
    .stat_addr  (stat_addr)
);

// File: tb/ecc_rmw_engine_tb.sv
`timescale 1ns/1ps
module ecc_rmw_engine_tb;

    localparam int AW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcl_valid = 1'b0;
    logic          lcl_ready;
    logic          lcl_write = 1'b0;
    logic [AW-1:0] lcl_addr = '0;
    logic [31:0]   lcl_wdata = '0;
    logic [3:0]    lcl_be = '0;
    logic          lcl_rvalid;
    logic [31:0]   lcl_rdata;
    logic          lcl_rerr;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [38:0]   mem_wdata;
    logic          mem_rvalid;
    logic [38:0]   mem_rdata;
    logic          irq;
    logic          stat_clr = 1'b0;
    logic          cnt_clr = 1'b0;
    logic [CW-1:0] sbe_cnt;
    logic [CW-1:0] dbe_cnt;
    logic          stat_valid;
    logic [1:0]    stat_type;
    logic [AW-1:0] stat_addr;

    logic          inj_valid = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [38:0]   inj_mask = '0;

    logic [38:0]   mem [0:255];
    int            n_rd = 0;
    int            n_wr = 0;
    int            checks = 0;
    int            errors = 0;
    logic [32:0]   exp_q [$];

    always #2 clk = ~clk;

    ecc_rmw_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_ready(lcl_ready), .lcl_write(lcl_write),
        .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_be(lcl_be),
        .lcl_rvalid(lcl_rvalid), .lcl_rdata(lcl_rdata), .lcl_rerr(lcl_rerr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .irq(irq), .stat_clr(stat_clr), .cnt_clr(cnt_clr),
        .sbe_cnt(sbe_cnt), .dbe_cnt(dbe_cnt), .stat_valid(stat_valid),
        .stat_type(stat_type), .stat_addr(stat_addr)
    );

    // Memory model: one-cycle read latency, bench-side bit flips.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (inj_valid) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
            if (mem_req) begin
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    n_wr = n_wr + 1;
                end else begin
                    mem_rdata  <= mem[mem_addr];
                    mem_rvalid <= 1'b1;
                    n_rd = n_rd + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && lcl_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected read response", 64'(lcl_rdata), 64'hDEAD);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                chk("R4/R7/R8 read data and error flag", 64'({lcl_rerr, lcl_rdata}), 64'(e));
            end
        end
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a,
                         input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        while (!lcl_ready) @(negedge clk);
        lcl_valid = 1'b1;
        lcl_write = wr;
        lcl_addr  = a;
        lcl_wdata = d;
        lcl_be    = be;
        @(negedge clk);
        lcl_valid = 1'b0;
        if (wr && be != 4'hF) chk("R3 ready low during read-modify-write", 64'(lcl_ready), 64'h0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] d, input logic err);
        exp_q.push_back({err, d});
        issue(1'b0, a, 32'h0, 4'h0);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [38:0] m);
        settle();
        inj_valid = 1'b1;
        inj_addr  = a;
        inj_mask  = m;
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic pulse_stat_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic pulse_cnt_clr();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int rd0, wr0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 ready after reset", 64'(lcl_ready), 64'h1);
        chk("R12 irq/stat_valid/rvalid/mem_req low", 64'({irq, stat_valid, lcl_rvalid, mem_req}), 64'h0);
        chk("R12 counters zero", 64'({sbe_cnt, dbe_cnt}), 64'h0);

        // R1 full write: one write, no read
        rd0 = n_rd; wr0 = n_wr;
        issue(1'b1, 8'h10, 32'h12345678, 4'hF);
        settle();
        chk("R1 full write reads", 64'(n_rd - rd0), 64'h0);
        chk("R1 full write writes", 64'(n_wr - wr0), 64'h1);
        rd(8'h10, 32'h12345678, 1'b0);

        // R11 codeword layout: d0 at index 2, d1 at 4, d2 at 5, even parity
        issue(1'b1, 8'h50, 32'h00000003, 4'hF);
        settle();
        chk("R11 d0,d1,d2 placement", 64'({mem[8'h50][2], mem[8'h50][4], mem[8'h50][5]}), 64'h6);
        chk("R11 overall even parity", 64'(^mem[8'h50]), 64'h0);

        // R2/R3 partial write then immediate read of the same address
        settle();
        rd0 = n_rd; wr0 = n_wr;
        issue(1'b1, 8'h10, 32'hAABBCCDD, 4'b0101);
        rd(8'h10, 32'h12BB56DD, 1'b0);
        settle();
        chk("R2 partial write memory reads", 64'(n_rd - rd0), 64'h2);
        chk("R2 partial write memory writes", 64'(n_wr - wr0), 64'h1);

        // R4/R6 single data-bit error on ordinary read (index 9 = d5)
        inject(8'h10, 39'h1 << 9);
        rd(8'h10, 32'h12BB56DD, 1'b0);
        settle();
        chk("R6 sbe count after read", 64'(sbe_cnt), 64'h1);

        // R6 corrected word written back by read-modify-write
        issue(1'b1, 8'h10, 32'h77000000, 4'b1000);
        settle();
        chk("R6 sbe count after rmw read", 64'(sbe_cnt), 64'h2);
        rd(8'h10, 32'h77BB56DD, 1'b0);
        settle();
        chk("R6 scrubbed word reads clean", 64'(sbe_cnt), 64'h2);

        // R5 check-bit error at Hamming position 1
        inject(8'h10, 39'h1);
        rd(8'h10, 32'h77BB56DD, 1'b0);
        settle();
        chk("R5 check bit counted", 64'(sbe_cnt), 64'h3);
        // R5 overall parity bit
        issue(1'b1, 8'h10, 32'h0BADF00D, 4'hF);
        inject(8'h10, 39'h1 << 38);
        rd(8'h10, 32'h0BADF00D, 1'b0);
        settle();
        chk("R5 parity bit counted", 64'(sbe_cnt), 64'h4);

        // R7/R9 double error on ordinary read: flip d0 and d1
        issue(1'b1, 8'h20, 32'h12345678, 4'hF);
        inject(8'h20, 39'h14);
        rd(8'h20, 32'h1234567B, 1'b1);
        settle();
        chk("R7 dbe count", 64'(dbe_cnt), 64'h1);
        chk("R7 irq raised", 64'(irq), 64'h1);
        chk("R9 status record", 64'({stat_valid, stat_type, stat_addr}), 64'({1'b1, 2'b01, 8'h20}));

        // R8/R9 double error during read-modify-write still writes
        issue(1'b1, 8'h30, 32'h12345678, 4'hF);
        inject(8'h30, 39'h14);
        issue(1'b1, 8'h30, 32'h00009900, 4'b0010);
        settle();
        chk("R8 dbe count after rmw", 64'(dbe_cnt), 64'h2);
        chk("R9 first error held", 64'({stat_type, stat_addr}), 64'({2'b01, 8'h20}));
        rd(8'h30, 32'h1234997B, 1'b0);
        settle();
        chk("R8 rewritten word clean", 64'(dbe_cnt), 64'h2);

        // R9 clear
        pulse_stat_clr();
        @(negedge clk);
        chk("R9 clear drops irq and status", 64'({irq, stat_valid}), 64'h0);

        // R9 rmw type recorded after clear
        inject(8'h30, 39'h14);
        issue(1'b1, 8'h30, 32'h00000011, 4'b0001);
        settle();
        chk("R9 rmw type", 64'({stat_valid, stat_type, stat_addr}), 64'({1'b1, 2'b10, 8'h30}));

        // R10 clear and saturation
        pulse_cnt_clr();
        @(negedge clk);
        chk("R10 counters cleared", 64'({sbe_cnt, dbe_cnt}), 64'h0);
        issue(1'b1, 8'h40, 32'hCAFEBABE, 4'hF);
        inject(8'h40, 39'h1 << 9);
        for (int i = 0; i < 18; i++) rd(8'h40, 32'hCAFEBABE, 1'b0);
        settle();
        chk("R10 sbe saturates", 64'(sbe_cnt), 64'hF);

        settle();
        chk("R4 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule